// File: doc/BRIEF.md
# TDM Backplane Timeslot Interleaver

This block sits between four 2.048 Mb/s serial TDM channels and a backplane. In the transmit direction it collects the bytes the four channels present during one frame and sends them on the backplane during the next frame. In the receive direction it collects backplane bytes during one frame and hands them to the four channels during the next frame. The channels always run at 2.048 Mb/s: one bit every four clocks of the 8.192 MHz block clock. Each frame holds 32 eight-bit timeslots per channel, sent most significant bit first.

A mode input selects the backplane format. In aggregated mode the backplane is a single 8.192 Mb/s stream on lane 0 with 128 timeslots per frame. The byte for timeslot n of channel k travels in backplane timeslot 4n+k, so the channels are interleaved one byte at a time in the order 0, 1, 2, 3. In per-channel mode each channel has its own 2.048 Mb/s backplane lane and timeslots pass straight through with no reordering. Every timeslot carries payload, and none is reserved. A one-clock frame pulse aligns the frame counter. The mode input is sampled only on that pulse, so a frame never mixes the two mappings.

Top module: `tdm_slot_interleaver`

## Requirements
- R1: While `rst_ni` is low, and in the first clock after it rises, `bp_tx_o` and `line_rx_o` are all zero.
- R2: With `mode_agg_i`=1 latched, the bit on `bp_tx_o[0]` at frame clock p (0..1023) is bit 7-(p mod 8) of the byte that channel (p/8) mod 4 delivered for timeslot p/32 in the previous frame. One backplane bit lasts one clock.
- R3: While aggregated mode is in effect, `bp_tx_o[3:1]` stay at 0.
- R4: With `mode_agg_i`=0 latched, `bp_tx_o[k]` at frame clock p carries bit 7-((p/4) mod 8) of channel k's timeslot p/32 from the previous frame.
- R5: In a frame captured in aggregated mode, the byte in backplane timeslot s on `bp_rx_i[0]` is sent on `line_rx_o[s mod 4]` in timeslot s/4 of the next frame. `bp_rx_i[3:1]` have no effect.
- R6: In a frame captured in per-channel mode, the byte in timeslot n on `bp_rx_i[k]` is sent on `line_rx_o[k]` in timeslot n of the next frame.
- R7: Every 2.048 Mb/s bit j of a frame occupies frame clocks 4j to 4j+3. Such inputs are sampled only in clock 4j+3, and such outputs hold one value over all four clocks.
- R8: The clock after a cycle with `frame_pulse_i` high is frame clock 0. Otherwise the frame clock advances by one and wraps from 1023 to 0.
- R9: `mode_agg_i` (1 = aggregated, 0 = per-channel) is taken only in a cycle with `frame_pulse_i` high. Changes between pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 8.192 MHz block clock, one high-rate bit per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| frame_pulse_i | input | 1 | One-clock frame marker; the next clock is frame clock 0 |
| mode_agg_i | input | 1 | Backplane format for the next frame: 1 aggregated, 0 per-channel |
| line_tx_i | input | 4 | Channel serial inputs, one per channel, 2.048 Mb/s |
| bp_tx_o | output | 4 | Backplane transmit lanes (lane 0 only in aggregated mode) |
| bp_rx_i | input | 4 | Backplane receive lanes (lane 0 only in aggregated mode) |
| line_rx_o | output | 4 | Channel serial outputs, one per channel, 2.048 Mb/s |

## Verification
The bench starts with a short first frame, ended early by the frame pulse. A design that ignored the pulse or restarted its counter one clock late would shift every following byte across a slot boundary. On the 2.048 Mb/s inputs the bench drives random values outside the sampling clock, and random data on the unused backplane lanes in aggregated mode. A design that sampled at the wrong point, or listened to lanes 1 to 3, would corrupt the received bytes. The mode switches several times at frame pulses, and in two frames the mode input pulses high in the middle of the frame. A design that acted on the mode mid-frame, or read a frame back with the wrong mapping after a switch, would send bytes to the wrong channel or timeslot.

// File: rtl/tdm_ilv_pkg.sv
package tdm_ilv_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned SLOTS  = 32;
  localparam int unsigned BITS   = 8;
  localparam int unsigned LW = $clog2(NUM_CH);
  localparam int unsigned BW = $clog2(BITS);
  localparam int unsigned WW = $clog2(SLOTS);
  localparam int unsigned CW = LW + BW + WW;

  typedef logic [CW-1:0] pos_t;
  typedef logic [WW-1:0] word_t;
  typedef logic [LW-1:0] lane_t;
  typedef logic [BW-1:0] bidx_t;
  typedef logic [BITS-1:0] byte_t;
  typedef enum logic {MODE_LANE = 1'b0, MODE_AGG = 1'b1} bp_mode_e;

  // channel timeslot index shared by both rates
  function automatic word_t word_of(pos_t p);
    return p[CW-1 -: WW];
  endfunction
  // high-rate: which channel owns the current backplane byte
  function automatic lane_t hr_lane(pos_t p);
    return p[BW +: LW];
  endfunction
  function automatic bidx_t hr_bit(pos_t p);
    return ~p[BW-1:0];
  endfunction
  function automatic logic hr_last(pos_t p);
    return &p[BW-1:0];
  endfunction
  // low-rate: four clocks per bit
  function automatic bidx_t lr_bit(pos_t p);
    return ~p[LW +: BW];
  endfunction
  function automatic logic lr_tick(pos_t p);
    return &p[LW-1:0];
  endfunction
  function automatic logic lr_last(pos_t p);
    return &p[LW+BW-1:0];
  endfunction
  function automatic logic lr_start(pos_t p);
    return p[LW-1:0] == '0;
  endfunction
endpackage

// File: rtl/tdm_ilv_timer.sv
module tdm_ilv_timer
  import tdm_ilv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     frame_pulse_i,
  input  logic     mode_agg_i,
  output pos_t     pos_q,
  output pos_t     pos_nxt,
  output bp_mode_e mode_q,
  output bp_mode_e mode_nxt,
  output logic     bank_q,
  output logic     bank_nxt
);
  always_comb begin
    pos_nxt  = frame_pulse_i ? '0 : pos_q + pos_t'(1);
    mode_nxt = frame_pulse_i ? (mode_agg_i ? MODE_AGG : MODE_LANE) : mode_q;
    bank_nxt = bank_q ^ frame_pulse_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      mode_q <= MODE_LANE;
      bank_q <= 1'b0;
    end else begin
      pos_q  <= pos_nxt;
      mode_q <= mode_nxt;
      bank_q <= bank_nxt;
    end
  end

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i |=> pos_q == '0);
  p_advance_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_pulse_i |=> pos_q == $past(pos_q) + pos_t'(1));
  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_pulse_i |=> $stable(mode_q));
  p_bank_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_pulse_i |=> bank_q != $past(bank_q));
endmodule

// File: rtl/tdm_ilv_deser.sv
module tdm_ilv_deser
  import tdm_ilv_pkg::*;
#(
  parameter bit AGG_CAP = 1'b0
)(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  pos_t                          pos_q,
  input  bp_mode_e                      mode_q,
  input  logic [NUM_CH-1:0]             ser_i,
  output logic [NUM_CH-1:0]             wr_en,
  output word_t                         wr_word,
  output logic [NUM_CH-1:0][BITS-1:0]   wr_data
);
  logic [NUM_CH-1:0][BITS-2:0] lane_sh;
  logic                        agg_active;
  logic [NUM_CH-1:0]           hr_en;
  byte_t                       hr_byte;

  assign agg_active = AGG_CAP && (mode_q == MODE_AGG);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lane_sh <= '0;
    end else if (lr_tick(pos_q)) begin
      for (int k = 0; k < NUM_CH; k++) begin
        lane_sh[k] <= {lane_sh[k][BITS-3:0], ser_i[k]};
      end
    end
  end

  generate
    if (AGG_CAP) begin : g_hr
      logic [BITS-2:0] hr_sh;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) hr_sh <= '0;
        else         hr_sh <= {hr_sh[BITS-3:0], ser_i[0]};
      end
      assign hr_byte = {hr_sh, ser_i[0]};
      assign hr_en   = hr_last(pos_q)
                       ? ({{(NUM_CH-1){1'b0}}, 1'b1} << hr_lane(pos_q)) : '0;
    end else begin : g_no_hr
      assign hr_byte = '0;
      assign hr_en   = '0;
    end
  endgenerate

  always_comb begin
    wr_word = word_of(pos_q);
    if (agg_active) begin
      wr_en   = hr_en;
      wr_data = {NUM_CH{hr_byte}};
    end else begin
      wr_en = {NUM_CH{lr_last(pos_q)}};
      for (int k = 0; k < NUM_CH; k++) wr_data[k] = {lane_sh[k], ser_i[k]};
    end
  end

  p_single_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agg_active |-> $onehot0(wr_en));
  p_lane_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !agg_active |-> (wr_en == '0 || &wr_en));
endmodule

// File: rtl/tdm_ilv_ser.sv
module tdm_ilv_ser
  import tdm_ilv_pkg::*;
#(
  parameter bit AGG_PLAY = 1'b0
)(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  pos_t                        pos_q,
  input  pos_t                        pos_nxt,
  input  bp_mode_e                    mode_q,
  input  bp_mode_e                    mode_nxt,
  input  logic [NUM_CH-1:0][BITS-1:0] rd_data,
  output logic [NUM_CH-1:0]           ser_o
);
  logic              use_agg;
  logic              lane_now;
  logic              hr_val;
  logic [NUM_CH-1:0] lane_bits;

  assign use_agg  = AGG_PLAY && (mode_nxt == MODE_AGG);
  assign lane_now = !(AGG_PLAY && (mode_q == MODE_AGG));

  generate
    if (AGG_PLAY) begin : g_hr
      assign hr_val = rd_data[hr_lane(pos_nxt)][hr_bit(pos_nxt)];
    end else begin : g_no_hr
      assign hr_val = 1'b0;
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) lane_bits[k] = rd_data[k][lr_bit(pos_nxt)];
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                 ser_o <= '0;
    else if (use_agg)            ser_o <= {{(NUM_CH-1){1'b0}}, hr_val};
    else if (lr_start(pos_nxt))  ser_o <= lane_bits;
  end

  generate
    if (AGG_PLAY) begin : g_chk
      p_quiet_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_q == MODE_AGG |-> ser_o[NUM_CH-1:1] == '0);
    end
  endgenerate

  p_lane_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_now && pos_q[LW-1:0] != '0) |-> $stable(ser_o));
endmodule

// File: rtl/tdm_ilv_path.sv
module tdm_ilv_path
  import tdm_ilv_pkg::*;
#(
  parameter bit IN_AGG  = 1'b0,
  parameter bit OUT_AGG = 1'b0
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pos_t              pos_q,
  input  pos_t              pos_nxt,
  input  bp_mode_e          mode_q,
  input  bp_mode_e          mode_nxt,
  input  logic              bank_q,
  input  logic              bank_nxt,
  input  logic [NUM_CH-1:0] ser_i,
  output logic [NUM_CH-1:0] ser_o
);
  localparam int unsigned DEPTH = 2 * SLOTS;

  logic [NUM_CH-1:0]           wr_en;
  word_t                       wr_word;
  logic [NUM_CH-1:0][BITS-1:0] wr_data;
  logic [NUM_CH-1:0][BITS-1:0] rd_data;

  tdm_ilv_deser #(.AGG_CAP(IN_AGG)) u_deser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pos_q   (pos_q),
    .mode_q  (mode_q),
    .ser_i   (ser_i),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .wr_data (wr_data)
  );

  // one array per channel; address = {bank, channel timeslot}
  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
      byte_t mem [DEPTH];
      always_ff @(posedge clk_i) begin
        if (wr_en[k]) mem[{bank_q, wr_word}] <= wr_data[k];
      end
      assign rd_data[k] = mem[{~bank_nxt, word_of(pos_nxt)}];
    end
  endgenerate

  tdm_ilv_ser #(.AGG_PLAY(OUT_AGG)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_q    (pos_q),
    .pos_nxt  (pos_nxt),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .rd_data  (rd_data),
    .ser_o    (ser_o)
  );
endmodule

// File: rtl/tdm_slot_interleaver.sv
module tdm_slot_interleaver
  import tdm_ilv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_pulse_i,
  input  logic              mode_agg_i,
  input  logic [NUM_CH-1:0] line_tx_i,
  output logic [NUM_CH-1:0] bp_tx_o,
  input  logic [NUM_CH-1:0] bp_rx_i,
  output logic [NUM_CH-1:0] line_rx_o
);
  pos_t     pos_q, pos_nxt;
  bp_mode_e mode_q, mode_nxt;
  logic     bank_q, bank_nxt;

  tdm_ilv_timer u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_pulse_i (frame_pulse_i),
    .mode_agg_i    (mode_agg_i),
    .pos_q         (pos_q),
    .pos_nxt       (pos_nxt),
    .mode_q        (mode_q),
    .mode_nxt      (mode_nxt),
    .bank_q        (bank_q),
    .bank_nxt      (bank_nxt)
  );

  // channels -> backplane
  tdm_ilv_path #(.IN_AGG(1'b0), .OUT_AGG(1'b1)) u_tx (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .pos_q (pos_q), .pos_nxt (pos_nxt),
    .mode_q (mode_q), .mode_nxt (mode_nxt),
    .bank_q (bank_q), .bank_nxt (bank_nxt),
    .ser_i (line_tx_i), .ser_o (bp_tx_o)
  );

  // backplane -> channels
  tdm_ilv_path #(.IN_AGG(1'b1), .OUT_AGG(1'b0)) u_rx (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .pos_q (pos_q), .pos_nxt (pos_nxt),
    .mode_q (mode_q), .mode_nxt (mode_nxt),
    .bank_q (bank_q), .bank_nxt (bank_nxt),
    .ser_i (bp_rx_i), .ser_o (line_rx_o)
  );
endmodule

// File: tb/tdm_slot_interleaver_tb_top.sv
module tdm_slot_interleaver_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, fp, mode_sel;
  logic [3:0] line_tx, bp_tx, bp_rx, line_rx;

  tdm_slot_interleaver dut_i (
    .clk_i (clk), .rst_ni (rst_n), .frame_pulse_i (fp), .mode_agg_i (mode_sel),
    .line_tx_i (line_tx), .bp_tx_o (bp_tx), .bp_rx_i (bp_rx), .line_rx_o (line_rx)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // behavioural reference: per-frame byte tables indexed [channel][timeslot]
  logic [7:0] tx_src [4][32], tx_play [4][32];
  logic [7:0] rx_src [4][32], rx_play [4][32];
  int mpos = 0, frames = 0;
  bit mmode = 1'b0, cap_mode = 1'b0, cmp_on = 1'b0;
  bit mode_for [14] = '{1,1,1,0,0,1,0,0,1,0,0,1,0,1};

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s frame=%0d pos=%0d actual=%b expected=%b", tag, frames, mpos, act, exp);
    end
  endtask

  task automatic refill();
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 32; n++) begin
        tx_src[k][n] = 8'($urandom);
        rx_src[k][n] = 8'($urandom);
      end
  endtask

  task automatic drive();
    int lb, hb, ts;
    lb = 7 - ((mpos / 4) % 8);
    hb = 7 - (mpos % 8);
    ts = mpos / 32;
    fp = (frames == 0) ? (mpos == 499) : (mpos == 1023);
    mode_sel = mode_for[frames];
    if ((frames == 4 || frames == 10) && mpos >= 300 && mpos < 600) mode_sel = 1'b1;
    for (int k = 0; k < 4; k++)
      line_tx[k] = (mpos % 4 == 3) ? tx_src[k][ts][lb] : 1'($urandom);
    if (mmode) begin
      bp_rx = 4'($urandom);
      bp_rx[0] = rx_src[(mpos / 8) % 4][ts][hb];
    end else begin
      for (int k = 0; k < 4; k++)
        bp_rx[k] = (mpos % 4 == 3) ? rx_src[k][ts][lb] : 1'($urandom);
    end
  endtask

  task automatic compare();
    logic [3:0] etx, erx;
    string sfx;
    int lb, ts;
    lb = 7 - ((mpos / 4) % 8);
    ts = mpos / 32;
    sfx = (frames == 5 || frames == 11) ? " R9" : "";
    for (int k = 0; k < 4; k++) erx[k] = rx_play[k][ts][lb];
    if (mmode) begin
      etx = 4'b0;
      etx[0] = tx_play[(mpos / 8) % 4][ts][7 - (mpos % 8)];
      check(bp_tx[0] == etx[0], {"R2", sfx}, bp_tx, etx);
      check(bp_tx[3:1] == 3'b0, {"R3", sfx}, bp_tx, etx);
    end else begin
      for (int k = 0; k < 4; k++) etx[k] = tx_play[k][ts][lb];
      check(bp_tx == etx, {"R4 R7", sfx}, bp_tx, etx);
    end
    if (mpos == 0) check(bp_tx == etx, "R8 slot0 alignment", bp_tx, etx);
    check(line_rx == erx, cap_mode ? "R5" : "R6 R7", line_rx, erx);
  endtask

  initial begin
    rst_n = 1'b0; fp = 1'b0; mode_sel = 1'b1; line_tx = '0; bp_rx = '0;
    refill();
    repeat (5) @(negedge clk);
    check(bp_tx == 4'b0 && line_rx == 4'b0, "R1 in reset", {bp_tx | line_rx}, 4'b0);
    rst_n = 1'b1;
    mpos = 0;
    drive();
    @(posedge clk);
    mpos = (fp) ? 0 : mpos + 1;
    @(negedge clk);
    check(bp_tx == 4'b0 && line_rx == 4'b0, "R1 after release", {bp_tx | line_rx}, 4'b0);
    drive();
    while (frames < 14) begin
      @(posedge clk);
      if (fp) begin
        tx_play = tx_src;
        rx_play = rx_src;
        cap_mode = mmode;
        mmode = mode_sel;
        refill();
        frames++;
        mpos = 0;
        cmp_on = (frames >= 2);
      end else begin
        mpos = (mpos + 1) % 1024;
      end
      @(negedge clk);
      if (cmp_on && frames < 14) compare();
      if (frames < 14) drive();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule